// File: doc/BRIEF.md
# Pseudo-Mersenne Modular Reducer

This block takes one wide unsigned operand `x` of `N` bits and returns `x mod m`, where the modulus `m = 2^K - a` is fixed when the block is built and `a` is a small constant. The reduction never divides. The value is held as a low part `r` of `K` bits and a high part `q`. Each clock the block replaces `q * 2^K` with `q * a`, which is equal modulo `m`. The low `K` bits of that product are added into `r`. The product's upper bits, together with any carry out of that addition, become the next `q`. When `q` reaches zero, `r` is below `2^K`, and one conditional subtraction of `m` brings it into range.

The operand enters through a valid/ready pair. `in_ready` is high only while the block is idle, so a source holding `in_valid` simply waits. The result leaves as a one-cycle `out_valid` pulse with `out_z`. The output has no back-pressure, so the consumer must capture the result in that cycle. One operand is in flight at a time. The multiplier inside the fold step is a carry-save array of `(N-K)` by `(K-1)` cells, and it fixes the clock period.

The modulus must satisfy `a = 2^K - m`, with `0 < a < 2^(K-1)` and `K >= 3`. Under these conditions `q` at least roughly halves on every fold, so the loop always ends.

Top module: `pmr_reducer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: For every accepted `N`-bit operand `x`, the `out_z` presented with `out_valid` equals `x mod m` as an unsigned `K`-bit number.
- R3: Every `out_z` presented with `out_valid` is strictly less than `m`, because a value at or above `m` is corrected by a single subtraction.
- R4: An operand is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` stays 0 until the cycle in which `out_valid` is 1, and in that cycle `in_ready` is 1 again.
- R5: Each accepted operand produces exactly one `out_valid` cycle, and `out_valid` is never high for two cycles in a row.
- R6: `in_valid` and `in_x` are ignored while `in_ready` is 0. The result belongs to the operand that was accepted, and no extra result is produced for the ignored operand.
- R7: An operand below `2^K` (all bits from `K` up are zero) keeps the block busy for exactly one cycle. `out_valid` rises two edges after the accepting edge.
- R8: The block is never busy for more than `N-K+4` consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered on `in_x` |
| in_ready | output | 1 | Block is idle and will take an operand on this edge |
| in_x | input | N | Unsigned operand to reduce |
| out_valid | output | 1 | One-cycle pulse marking `out_z` as the result |
| out_z | output | K | Reduced value, `x mod m` |

## Verification
The properties assume a valid build: `a` is nonzero and below `2^(K-1)`. Under that assumption the fold count is bounded and the reference remainder of the captured operand matches the result. They also assume `in_x` is a known value whenever `in_valid` meets `in_ready`, and that no consumer needs `out_valid` to be held. The stimulus uses only moduli that meet the bound on `a`. It drives `in_x` as a stable, defined value together with `in_valid`, and it samples every result in its single pulse cycle, never depending on a stall.

// File: rtl/pmr_pkg.sv
`timescale 1ns/1ps
package pmr_pkg;

  // Sequencer phases of the reducer.
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_FOLD = 1'b1
  } pmr_phase_e;

  // Folding constant: distance from the modulus up to the next power of two.
  function automatic logic [31:0] pmr_fold_const(input int unsigned k, input logic [31:0] m);
    pmr_fold_const = (32'd1 << k) - m;
  endfunction

endpackage

// File: rtl/pmr_csa_cell.sv
`timescale 1ns/1ps
// One product cell: two-bit result of x*y + z + w.
module pmr_csa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  input  logic w_i,
  output logic s_o,
  output logic c_o
);
  logic pp;

  assign pp  = x_i & y_i;
  assign s_o = pp ^ z_i ^ w_i;
  assign c_o = (pp & z_i) | (pp & w_i) | (z_i & w_i);
endmodule

// File: rtl/pmr_csa_mult.sv
`timescale 1ns/1ps
// Unsigned carry-save array multiplier, one cell row per multiplier bit,
// closed by a single carry-propagate addition.
module pmr_csa_mult #(
  parameter int unsigned QW = 56,
  parameter int unsigned AW = 7
) (
  input  logic [QW-1:0]    mcand_i,
  input  logic [AW-1:0]    mplier_i,
  output logic [QW+AW-1:0] prod_o
);
  localparam int unsigned LAST = AW - 1;

  for (genvar j = 0; j < AW; j++) begin : g_row
    logic [QW-1:0] s_v;
    logic [QW-1:0] c_v;

    if (j == 0) begin : g_first
      assign s_v = mcand_i & {QW{mplier_i[0]}};
      assign c_v = '0;
    end else begin : g_next
      for (genvar i = 0; i < QW; i++) begin : g_cell
        logic z_b;
        if (i == QW - 1) begin : g_edge
          assign z_b = 1'b0;
        end else begin : g_inner
          assign z_b = g_row[j-1].s_v[i+1];
        end
        pmr_csa_cell u_cell (
          .x_i (mcand_i[i]),
          .y_i (mplier_i[j]),
          .z_i (z_b),
          .w_i (g_row[j-1].c_v[i]),
          .s_o (s_v[i]),
          .c_o (c_v[i])
        );
      end
    end

    // The lowest sum bit of each row is final.
    assign prod_o[j] = s_v[0];
  end

  // Resolve the remaining carry-save pair above the last row.
  assign prod_o[QW+AW-1:AW] = {1'b0, g_row[LAST].s_v[QW-1:1]} + g_row[LAST].c_v;
endmodule

// File: rtl/pmr_fold_step.sv
`timescale 1ns/1ps
// One fold: r + q*2^K  ->  r' + q'*2^K, equal modulo 2^K - a.
module pmr_fold_step #(
  parameter int unsigned K  = 8,
  parameter int unsigned QW = 56
) (
  input  logic [K-1:0]  r_i,
  input  logic [QW-1:0] q_i,
  input  logic [K-2:0]  a_i,
  output logic [K-1:0]  r_o,
  output logic [QW-1:0] q_o
);
  localparam int unsigned AW = K - 1;
  localparam int unsigned PW = QW + AW;

  logic [PW-1:0] prod;
  logic [K:0]    low_sum;

  pmr_csa_mult #(.QW(QW), .AW(AW)) u_mult (
    .mcand_i  (q_i),
    .mplier_i (a_i),
    .prod_o   (prod)
  );

  assign low_sum = {1'b0, r_i} + {1'b0, prod[K-1:0]};
  assign r_o     = low_sum[K-1:0];
  // Carry out of the low sum rides along with the product's upper bits.
  assign q_o     = {1'b0, prod[PW-1:K]} + {{(QW-1){1'b0}}, low_sum[K]};
endmodule

// File: rtl/pmr_final_sub.sv
`timescale 1ns/1ps
// Single conditional subtraction bringing r < 2^K into [0, m).
module pmr_final_sub #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] r_i,
  input  logic [K-1:0] m_i,
  output logic [K-1:0] z_o
);
  assign z_o = (r_i >= m_i) ? (r_i - m_i) : r_i;
endmodule

// File: rtl/pmr_reducer.sv
`timescale 1ns/1ps
module pmr_reducer
  import pmr_pkg::*;
#(
  parameter int unsigned   N   = 64,
  parameter int unsigned   K   = 8,
  parameter logic [K-1:0]  MOD = 8'hEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_x,
  output logic         out_valid,
  output logic [K-1:0] out_z
);
  localparam int unsigned  QW      = N - K;
  localparam int unsigned  AW      = K - 1;
  localparam logic [31:0]  A_FULL  = pmr_fold_const(K, 32'(MOD));
  localparam logic [AW-1:0] A_C    = A_FULL[AW-1:0];

  pmr_phase_e    phase_q;
  logic [K-1:0]  r_q;
  logic [QW-1:0] q_q;
  logic [K-1:0]  r_nx;
  logic [QW-1:0] q_nx;
  logic [K-1:0]  z_fin;
  logic          q_zero;
  logic          accept;
  logic          ov_q;
  logic [K-1:0]  z_q;

  assign in_ready = (phase_q == PH_IDLE);
  assign accept   = in_valid && in_ready;
  assign q_zero   = (q_q == '0);

  pmr_fold_step #(.K(K), .QW(QW)) u_fold (
    .r_i (r_q),
    .q_i (q_q),
    .a_i (A_C),
    .r_o (r_nx),
    .q_o (q_nx)
  );

  pmr_final_sub #(.K(K)) u_fix (
    .r_i (r_q),
    .m_i (MOD),
    .z_o (z_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      r_q     <= '0;
      q_q     <= '0;
      ov_q    <= 1'b0;
      z_q     <= '0;
    end else begin
      ov_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            r_q     <= in_x[K-1:0];
            q_q     <= in_x[N-1:K];
            phase_q <= PH_FOLD;
          end
        end
        PH_FOLD: begin
          if (q_zero) begin
            z_q     <= z_fin;
            ov_q    <= 1'b1;
            phase_q <= PH_IDLE;
          end else begin
            r_q <= r_nx;
            q_q <= q_nx;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign out_valid = ov_q;
  assign out_z     = z_q;
endmodule

// File: rtl/pmr_reducer_chk.sv
`timescale 1ns/1ps
module pmr_reducer_chk #(
  parameter int unsigned  N   = 64,
  parameter int unsigned  K   = 8,
  parameter logic [K-1:0] MOD = 8'hEF
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] in_x,
  input logic         out_valid,
  input logic [K-1:0] out_z
);
  localparam int unsigned BOUND = N - K + 4;

  logic [N-1:0] x_hold;
  logic [N-1:0] rem;
  logic [15:0]  busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_hold   <= '0;
      busy_cnt <= '0;
    end else begin
      if (in_valid && in_ready) x_hold <= in_x;
      if (in_ready) busy_cnt <= '0;
      else if (busy_cnt != '1) busy_cnt <= busy_cnt + 16'd1;
    end
  end

  assign rem = x_hold % {{(N-K){1'b0}}, MOD};

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid));

  p_exact_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({{(N-K){1'b0}}, out_z} == rem));

  p_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_z < MOD));

  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_ready_on_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_result_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  p_short_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ((in_x >> K) == '0)) |=> ##1 out_valid);

  p_bounded_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (busy_cnt < 16'(BOUND)));
endmodule

bind pmr_reducer pmr_reducer_chk #(.N(N), .K(K), .MOD(MOD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_x      (in_x),
  .out_valid (out_valid),
  .out_z     (out_z)
);

// File: tb/sim_pmr_reducer.sv
`timescale 1ns/1ps
module sim_pmr_reducer;
  // Small build swept exhaustively: m = 29 = 2^5 - 3.
  localparam int unsigned N0 = 12;
  localparam int unsigned K0 = 5;
  localparam logic [K0-1:0] M0 = 5'd29;
  // Default-sized build: m = 0xEF = 2^8 - 0x11.
  localparam int unsigned N1 = 64;
  localparam int unsigned K1 = 8;
  localparam logic [K1-1:0] M1 = 8'hEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   total = 0;
  int   bad   = 0;

  logic          iv0 = 1'b0, ir0, ov0;
  logic [N0-1:0] x0 = '0;
  logic [K0-1:0] z0;
  logic          iv1 = 1'b0, ir1, ov1;
  logic [N1-1:0] x1 = '0;
  logic [K1-1:0] z1;

  always #2 clk = ~clk;

  pmr_reducer #(.N(N0), .K(K0), .MOD(M0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv0), .in_ready(ir0),
    .in_x(x0), .out_valid(ov0), .out_z(z0));

  pmr_reducer #(.N(N1), .K(K1), .MOD(M1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv1), .in_ready(ir1),
    .in_x(x1), .out_valid(ov1), .out_z(z1));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Offer x to u0, wait for its result, check it; lat returns busy cycles.
  task automatic run0(input logic [N0-1:0] x, output int lat);
    logic [N0-1:0] exp;
    exp = x % {{(N0-K0){1'b0}}, M0};
    @(negedge clk);
    chk(ir0 == 1'b1, "R4", "ready when idle", 64'(ir0), 64'd1);
    iv0 = 1'b1; x0 = x;
    @(negedge clk);
    iv0 = 1'b0;
    lat = 0;
    while (!ov0 && lat < 100) begin
      chk(ir0 == 1'b0, "R4", "busy until result", 64'(ir0), 64'd0);
      @(negedge clk);
      lat++;
    end
    chk(ov0 == 1'b1, "R8", "result arrived", 64'(ov0), 64'd1);
    chk(z0 == exp[K0-1:0], "R2", "small build remainder", 64'(z0), 64'(exp));
    chk(z0 < M0, "R3", "below modulus", 64'(z0), 64'(M0));
    chk(ir0 == 1'b1, "R4", "ready in result cycle", 64'(ir0), 64'd1);
    chk(lat <= int'(N0 - K0 + 4), "R8", "busy bound", 64'(lat), 64'(N0 - K0 + 4));
    @(negedge clk);
    chk(ov0 == 1'b0, "R5", "single pulse", 64'(ov0), 64'd0);
  endtask

  task automatic run1(input logic [N1-1:0] x, output int lat);
    logic [N1-1:0] exp;
    exp = x % {{(N1-K1){1'b0}}, M1};
    @(negedge clk);
    iv1 = 1'b1; x1 = x;
    @(negedge clk);
    iv1 = 1'b0;
    lat = 0;
    while (!ov1 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(z1 == exp[K1-1:0], "R2", "wide build remainder", 64'(z1), exp);
    chk(z1 < M1, "R3", "below modulus", 64'(z1), 64'(M1));
    chk(lat <= int'(N1 - K1 + 4), "R8", "busy bound", 64'(lat), 64'(N1 - K1 + 4));
    @(negedge clk);
    chk(ov1 == 1'b0, "R5", "single pulse", 64'(ov1), 64'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int lat;
    int max_lat;
    repeat (3) @(negedge clk);
    chk(ir0 == 1'b1 && ov0 == 1'b0, "R1", "idle in reset", {62'd0, ir0, ov0}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ir1 == 1'b1 && ov1 == 1'b0, "R1", "idle after reset", {62'd0, ir1, ov1}, 64'd2);

    // R7: operands below 2^K finish after one busy cycle.
    run0(12'd17, lat);
    chk(lat == 1, "R7", "short operand latency", 64'(lat), 64'd1);
    run0(12'd30, lat);
    chk(lat == 1, "R7", "short operand at/above m", 64'(lat), 64'd1);
    chk(z0 == 5'd1, "R3", "30 mod 29", 64'(z0), 64'd1);
    run0(12'd0, lat);
    chk(lat == 1, "R7", "zero operand", 64'(lat), 64'd1);

    // Exhaustive sweep of the small build.
    max_lat = 0;
    for (int v = 0; v < (1 << N0); v++) begin
      run0(v[N0-1:0], lat);
      if (lat > max_lat) max_lat = lat;
    end
    $display("small build: worst busy cycles = %0d", max_lat);

    // Known vector on the default build.
    run1(64'h41C1D298F81A7296, lat);
    chk(z1 == 8'h7F, "R2", "known vector", 64'(z1), 64'h7F);
    $display("wide build: vector busy cycles = %0d", lat);

    // R6: a second offer while busy is ignored.
    @(negedge clk);
    iv1 = 1'b1; x1 = 64'h41C1D298F81A7296;
    @(negedge clk);
    x1 = 64'hFFFF_FFFF_FFFF_FFFF;
    chk(ir1 == 1'b0, "R6", "busy during second offer", 64'(ir1), 64'd0);
    @(negedge clk);
    iv1 = 1'b0;
    lat = 0;
    while (!ov1 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(z1 == 8'h7F, "R6", "result of first operand", 64'(z1), 64'h7F);
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (ov1) chk(1'b0, "R6", "no result for ignored operand", 64'(ov1), 64'd0);
    end
    chk(ov1 == 1'b0 && ir1 == 1'b1, "R6", "idle after ignored offer", {62'd0, ir1, ov1}, 64'd2);

    // Extremes and random operands on the default build.
    run1(64'hFFFF_FFFF_FFFF_FFFF, lat);
    run1(64'h0000_0000_0000_00EF, lat);
    run1(64'h0000_0000_0000_0100, lat);
    max_lat = 0;
    for (int i = 0; i < 300; i++) begin
      run1({$urandom(), $urandom()}, lat);
      if (lat > max_lat) max_lat = lat;
    end
    $display("wide build: worst random busy cycles = %0d", max_lat);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule